// File: doc/BRIEF.md
# Command Stream Packet Header Parser

This block watches a stream of 32-bit command words that arrives under a valid/ready handshake. It treats the first word it sees, and every word after a packet ends, as a header. It sorts each header into one of five packet kinds and pulls out the register index or opcode and the number of payload words. It then forwards exactly that many payload words downstream, each one tagged with its packet kind and target.

Register-write packets step their register index by one on each payload word. Opcode packets keep the same opcode on every word. The final payload word of a packet carries a last flag.

The two newer header layouts guard each field with a parity bit. When the parity is wrong, the packet is consumed without producing any output, and a sticky error flag is set. A header whose top nibble names no known kind gives a one-cycle error pulse and is dropped. The block does not execute opcodes or perform register writes.

Top module: `cmd_hdr_parser`

## Requirements
- R1: The header kind is taken from bits 31:28. The value 0x0 selects kind 0, 0x8 kind 2, 0xC kind 3, 0x4 kind 4 and 0x7 kind 7. `out_kind` reports the kind number itself, as the values 0, 2, 3, 4 or 7.
- R2: Kind 0 carries a register index in bits 14:0. Kind 3 carries an opcode in bits 15:8. For both kinds, bits 27:16 hold the payload length minus one.
- R3: Kind 4 carries a raw length (0..127) in bits 6:0 and a register index in bits 25:8. Kind 7 carries a raw length in bits 14:0 and an opcode in bits 22:16.
- R4: Each checked field has an expected parity bit equal to the inverted XOR of all its bits. Kind 4 checks its length against bit 7 and its index against bit 27. Kind 7 checks its length against bit 15 and its opcode against bit 23. On a mismatch, the header and its decoded number of payload words are accepted with no output, and `err_parity` goes high and stays high until reset.
- R5: A header whose top nibble is any other value is dropped. It produces a one-cycle `err_bad_hdr` pulse in the cycle after acceptance, and the next word is parsed as a header.
- R6: Payload words appear on `out_data` unchanged. For kinds 0 and 4, `out_target` is the index plus the position of the word in the packet, and `out_is_reg` is 1. For kinds 3 and 7, `out_target` is the opcode on every word, and `out_is_reg` is 0.
- R7: `out_last` is high on the final payload word of a packet and on no other word.
- R8: A kind 2 header, or a kind 4 or kind 7 header with length zero, produces no output, and the next word is parsed as a header.
- R9: `in_ready` is 1 while the block waits for a header or discards words. During payload, `in_ready` follows `out_ready`, and the payload context stays unchanged while the output is stalled.
- R10: After reset, the block waits for a header, with `out_valid`, `err_parity` and `err_bad_hdr` low and `in_ready` high. A reset in the middle of a packet abandons that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| out_valid | output | 1 | Payload word valid |
| out_data | output | 32 | Payload word |
| out_kind | output | 3 | Packet kind of the payload word |
| out_target | output | 18 | Register index or opcode for this word |
| out_is_reg | output | 1 | Target is a register index |
| out_last | output | 1 | Final payload word of the packet |
| out_ready | input | 1 | Downstream accepts the payload word |
| err_bad_hdr | output | 1 | One-cycle pulse for an unknown header |
| err_parity | output | 1 | Sticky parity error flag |

## Verification
The bench targets the off-by-one between the minus-one length of the older layouts and the raw length of the newer ones. A design that gets this wrong emits one word too many or too few, and then misreads a payload word as a header. The bench also covers:
- Zero-length and no-op packets. A design that waits for a payload here swallows the next real header.
- Flipped parity bits in each guarded field. A design that checks the wrong bit, or forgets to discard the payload, leaks data downstream.
- Stalls. A design that advances the register index while stalled labels the next word with the wrong target.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int TGT_W  = 18;
    localparam int NPAR   = 4;
    localparam logic [15:0] PAR_LUT = 16'h9669;

    typedef enum logic [2:0] {
        K_REG0 = 3'd0,
        K_NOP  = 3'd2,
        K_OP3  = 3'd3,
        K_REG4 = 3'd4,
        K_OP7  = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        S_HDR  = 2'd0,
        S_PAY  = 2'd1,
        S_DROP = 2'd2
    } st_e;

    typedef struct packed {
        kind_e              kind;
        logic [CNT_W-1:0]   count;
        logic [TGT_W-1:0]   target;
        logic               is_reg;
        logic               bad;
        logic               par_bad;
    } hdr_info_t;
endpackage

// File: rtl/cmdp_parity.sv
module cmdp_parity #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    output logic         par
);
    import cmdp_pkg::*;
    localparam int NIB = (W + 3) / 4;

    logic [4*NIB-1:0] padded;
    logic [3:0]       fold;

    assign padded = (4*NIB)'(val);

    always_comb begin
        fold = 4'h0;
        for (int i = 0; i < NIB; i++) begin
            fold = fold ^ padded[4*i +: 4];
        end
    end

    assign par = PAR_LUT[fold];
endmodule

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_info_t         info
);
    // checked fields: 0 = kind4 length, 1 = kind4 index, 2 = kind7 length, 3 = kind7 opcode
    logic [WORD_W-1:0] fval [NPAR];
    logic [NPAR-1:0]   pcalc;

    assign fval[0] = WORD_W'(word[6:0]);
    assign fval[1] = WORD_W'(word[25:8]);
    assign fval[2] = WORD_W'(word[14:0]);
    assign fval[3] = WORD_W'(word[22:16]);

    generate
        for (genvar g = 0; g < NPAR; g++) begin : g_par
            cmdp_parity #(.W(WORD_W)) u_par (
                .val (fval[g]),
                .par (pcalc[g])
            );
        end
    endgenerate

    always_comb begin
        info         = '0;
        info.kind    = K_REG0;
        case (word[31:28])
            4'h0: begin
                info.kind   = K_REG0;
                info.count  = CNT_W'(word[27:16]) + CNT_W'(1);
                info.target = TGT_W'(word[14:0]);
                info.is_reg = 1'b1;
            end
            4'h8: begin
                info.kind   = K_NOP;
            end
            4'hC: begin
                info.kind   = K_OP3;
                info.count  = CNT_W'(word[27:16]) + CNT_W'(1);
                info.target = TGT_W'(word[15:8]);
            end
            4'h4: begin
                info.kind    = K_REG4;
                info.count   = CNT_W'(word[6:0]);
                info.target  = TGT_W'(word[25:8]);
                info.is_reg  = 1'b1;
                info.par_bad = (pcalc[0] != word[7]) || (pcalc[1] != word[27]);
            end
            4'h7: begin
                info.kind    = K_OP7;
                info.count   = CNT_W'(word[14:0]);
                info.target  = TGT_W'(word[22:16]);
                info.par_bad = (pcalc[2] != word[15]) || (pcalc[3] != word[23]);
            end
            default: begin
                info.bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cmd_hdr_parser.sv
module cmd_hdr_parser
    import cmdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic [2:0]        out_kind,
    output logic [TGT_W-1:0]  out_target,
    output logic              out_is_reg,
    output logic              out_last,
    input  logic              out_ready,
    output logic              err_bad_hdr,
    output logic              err_parity
);
    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] left;
        logic [TGT_W-1:0] tgt;
        kind_e            kind;
        logic             is_reg;
        logic             par_err;
        logic             bad_p;
    } regs_t;

    localparam regs_t RST = '{st: S_HDR, left: '0, tgt: '0, kind: K_REG0,
                              is_reg: 1'b0, par_err: 1'b0, bad_p: 1'b0};

    regs_t     d, q;
    hdr_info_t info;
    logic      rdy_c, vld_c;

    cmdp_hdr_decode u_dec (
        .word (in_data),
        .info (info)
    );

    always_comb begin
        d       = q;
        d.bad_p = 1'b0;
        rdy_c   = 1'b1;
        vld_c   = 1'b0;
        case (q.st)
            S_HDR: begin
                if (in_valid) begin
                    if (info.bad) begin
                        d.bad_p = 1'b1;
                    end else if (info.par_bad) begin
                        d.par_err = 1'b1;
                        if (info.count != '0) begin
                            d.st   = S_DROP;
                            d.left = info.count;
                        end
                    end else if (info.count != '0) begin
                        d.st     = S_PAY;
                        d.left   = info.count;
                        d.tgt    = info.target;
                        d.kind   = info.kind;
                        d.is_reg = info.is_reg;
                    end
                end
            end
            S_PAY: begin
                rdy_c = out_ready;
                vld_c = in_valid;
                if (in_valid && out_ready) begin
                    d.left = q.left - CNT_W'(1);
                    if (q.is_reg) d.tgt = q.tgt + TGT_W'(1);
                    if (q.left == CNT_W'(1)) d.st = S_HDR;
                end
            end
            S_DROP: begin
                if (in_valid) begin
                    d.left = q.left - CNT_W'(1);
                    if (q.left == CNT_W'(1)) d.st = S_HDR;
                end
            end
            default: begin
                d.st = S_HDR;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign in_ready    = rdy_c;
    assign out_valid   = vld_c;
    assign out_data    = in_data;
    assign out_kind    = q.kind;
    assign out_target  = q.tgt;
    assign out_is_reg  = q.is_reg;
    assign out_last    = (q.st == S_PAY) && (q.left == CNT_W'(1));
    assign err_bad_hdr = q.bad_p;
    assign err_parity  = q.par_err;
endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker
    import cmdp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_data,
    input logic              in_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic [2:0]        out_kind,
    input logic [TGT_W-1:0]  out_target,
    input logic              out_is_reg,
    input logic              out_last,
    input logic              out_ready,
    input logic              err_bad_hdr,
    input logic              err_parity
);
    AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |=> err_parity); // R4

    AST_BAD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        err_bad_hdr |-> $past(in_valid && in_ready)); // R5

    AST_REG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last && out_is_reg) |=>
        (!out_valid || out_target == TGT_W'($past(out_target) + TGT_W'(1)))); // R6

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_target) && $stable(out_last))); // R9

    AST_READY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready)); // R9

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_kind == 3'd0 || out_kind == 3'd3 ||
                       out_kind == 3'd4 || out_kind == 3'd7)); // R1

    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_valid && out_data == in_data)); // R6
endmodule

bind cmd_hdr_parser cmdp_checker u_chk (.*);

// File: tb/cmd_hdr_parser_tb.sv
module cmd_hdr_parser_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic [2:0]  out_kind;
    logic [17:0] out_target;
    logic        out_is_reg;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        err_bad_hdr;
    logic        err_parity;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cmd_hdr_parser u_dut (.*);

    function automatic logic par(input logic [31:0] v);
        return ~(^v);
    endfunction

    function automatic logic [31:0] mk4(input logic [17:0] r, input logic [6:0] c);
        return {4'h4, par(32'(r)), 1'b0, r, par(32'(c)), c};
    endfunction

    function automatic logic [31:0] mk7(input logic [6:0] op, input logic [14:0] c);
        return {4'h7, 4'h0, par(32'(op)), op, par(32'(c)), c};
    endfunction

    typedef struct packed {
        logic [31:0] hdr;
        logic [15:0] n;
        logic [2:0]  kind;
        logic [17:0] tgt;
        logic        isreg;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{hdr: 32'h0002_1234,            n: 16'd3,   kind: 3'd0, tgt: 18'h01234, isreg: 1'b1},
        '{hdr: 32'hC001_5A00,            n: 16'd2,   kind: 3'd3, tgt: 18'h0005A, isreg: 1'b0},
        '{hdr: mk4(18'h2ABCD, 7'd4),     n: 16'd4,   kind: 3'd4, tgt: 18'h2ABCD, isreg: 1'b1},
        '{hdr: mk7(7'h3F, 15'd5),        n: 16'd5,   kind: 3'd7, tgt: 18'h0003F, isreg: 1'b0},
        '{hdr: mk4(18'h00010, 7'd127),   n: 16'd127, kind: 3'd4, tgt: 18'h00010, isreg: 1'b1},
        '{hdr: 32'h8000_0000,            n: 16'd0,   kind: 3'd2, tgt: 18'h0,     isreg: 1'b0},
        '{hdr: mk4(18'h00005, 7'd0),     n: 16'd0,   kind: 3'd4, tgt: 18'h0,     isreg: 1'b1},
        '{hdr: 32'h0000_7FFF,            n: 16'd1,   kind: 3'd0, tgt: 18'h07FFF, isreg: 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w, input bit exp_v, input logic [17:0] exp_t,
                        input bit exp_last, input logic [2:0] exp_k, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        chk(out_valid == exp_v, req, "out_valid", 64'(out_valid), 64'(exp_v));
        if (exp_v) begin
            chk(out_data == w, req, "out_data", 64'(out_data), 64'(w));
            chk(out_target == exp_t, req, "out_target", 64'(out_target), 64'(exp_t));
            chk(out_last == exp_last, req, "out_last", 64'(out_last), 64'(exp_last));
            chk(out_kind == exp_k, req, "out_kind", 64'(out_kind), 64'(exp_k));
        end else begin
            chk(in_ready == 1'b1, req, "in_ready", 64'(in_ready), 64'd1);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10", "out_valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R10", "in_ready", 64'(in_ready), 64'd1);
        chk(err_parity == 1'b0 && err_bad_hdr == 1'b0, "R10", "errors",
            64'({err_parity, err_bad_hdr}), 64'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R6 R7 R8: table of packets
        for (int v = 0; v < NV; v++) begin
            push(VEC[v].hdr, 1'b0, '0, 1'b0, '0, "R1");
            for (int i = 0; i < int'(VEC[v].n); i++) begin
                push(32'hA500_0000 + 32'(v << 12) + 32'(i),
                     1'b1,
                     VEC[v].isreg ? VEC[v].tgt + 18'(i) : VEC[v].tgt,
                     (i == int'(VEC[v].n) - 1),
                     VEC[v].kind, "R6");
            end
        end
        chk(err_parity == 1'b0, "R4", "no false parity", 64'(err_parity), 64'd0);

        // R9: stall during payload
        push(32'h0001_0100, 1'b0, '0, 1'b0, '0, "R9");
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = 32'hDEAD_0001;
        out_ready = 1'b0;
        #1;
        chk(in_ready == 1'b0, "R9", "in_ready stalled", 64'(in_ready), 64'd0);
        chk(out_target == 18'h100, "R9", "target stalled", 64'(out_target), 64'h100);
        @(negedge clk);
        #1;
        chk(out_target == 18'h100, "R9", "target held", 64'(out_target), 64'h100);
        chk(out_last == 1'b0, "R9", "last held", 64'(out_last), 64'd0);
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R9", "in_ready released", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        push(32'hDEAD_0002, 1'b1, 18'h101, 1'b1, 3'd0, "R9");

        // R5: unknown header
        push(32'h1000_0000, 1'b0, '0, 1'b0, '0, "R5");
        chk(err_bad_hdr == 1'b1, "R5", "bad pulse", 64'(err_bad_hdr), 64'd1);
        @(posedge clk);
        #1;
        chk(err_bad_hdr == 1'b0, "R5", "pulse ends", 64'(err_bad_hdr), 64'd0);
        push(32'hC000_2200, 1'b0, '0, 1'b0, '0, "R5");
        push(32'h0BAD_0001, 1'b1, 18'h22, 1'b1, 3'd3, "R5");

        // R4: parity errors, payload discarded
        push(mk7(7'h11, 15'd2) ^ 32'h0000_8000, 1'b0, '0, 1'b0, '0, "R4");
        push(32'h1111_0000, 1'b0, '0, 1'b0, '0, "R4");
        push(32'h1111_0001, 1'b0, '0, 1'b0, '0, "R4");
        chk(err_parity == 1'b1, "R4", "sticky set", 64'(err_parity), 64'd1);
        push(mk4(18'h00033, 7'd1) ^ 32'h0800_0000, 1'b0, '0, 1'b0, '0, "R4");
        push(32'h2222_0000, 1'b0, '0, 1'b0, '0, "R4");
        push(mk7(7'h21, 15'd1) ^ 32'h0080_0000, 1'b0, '0, 1'b0, '0, "R4");
        push(32'h3333_0000, 1'b0, '0, 1'b0, '0, "R4");
        push(mk4(18'h00044, 7'd1) ^ 32'h0000_0080, 1'b0, '0, 1'b0, '0, "R4");
        push(32'h4444_0000, 1'b0, '0, 1'b0, '0, "R4");
        push(32'h8000_0000, 1'b0, '0, 1'b0, '0, "R8");
        chk(err_parity == 1'b1, "R4", "sticky held", 64'(err_parity), 64'd1);
        push(mk7(7'h05, 15'd1), 1'b0, '0, 1'b0, '0, "R4");
        push(32'h5555_0000, 1'b1, 18'h5, 1'b1, 3'd7, "R4");

        // R10: reset mid-packet
        push(32'h0003_0200, 1'b0, '0, 1'b0, '0, "R10");
        push(32'h6666_0000, 1'b1, 18'h200, 1'b0, 3'd0, "R10");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", "mid reset",
            64'({out_valid, in_ready}), 64'd1);
        chk(err_parity == 1'b0, "R10", "sticky cleared", 64'(err_parity), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        push(32'hC000_3300, 1'b0, '0, 1'b0, '0, "R10");
        push(32'h7777_0000, 1'b1, 18'h33, 1'b1, 3'd3, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule